// File: doc/BRIEF.md
# Fetch-Execute Program Flow Sequencer

This block sequences instruction fetch for a small 8-bit processor that keeps program and data in separate memories and uses 12-bit instructions. It holds the program counter and a hardware return stack. It puts an 11-bit fetch address out to a program memory whose read data is registered, one cycle after the address. Fetch and execute overlap. While the instruction in the execute slot runs, the word that follows it is already being read.

The decoder lives outside the block. It raises one of four request lines during the execute slot of a flow-changing instruction: jump, call, return or skip. Jump and call targets come in on the literal input. A taken request costs one extra cycle. The word that was already prefetched reaches the block's instruction output gated to all zeros, which is the no-operation encoding 0x000, and a squash flag is raised for that slot.

Reset works the same way. The counter is set to the last code address and the first slot is squashed. The first word actually fetched is therefore at address 0.

Top module: `fetch_sequencer`

## Requirements
- R1: In the first slot after a synchronous reset, `instr` is 0x000 and `squash` is 1 while `pmAddr` is 0. The slot after that executes the word read from address 0.
- R2: With no request, each slot executes the word at the previous slot's address plus one, modulo 2^ADDR_W, so 0x7FF is followed by 0x000. In every unsquashed slot, `pmAddr` equals the executing address plus one.
- R3: A jump in an unsquashed slot squashes the next slot and drives `target` onto `pmAddr` during that squashed slot. The word at `target` then executes in the slot after it, so the jump takes two cycles.
- R4: A call behaves as a jump. It also pushes the call's own address plus one onto the return stack.
- R5: A return squashes the next slot and resumes at the top stack entry. Entry 2 moves up to entry 1 and entry 2 keeps its value. All entries reset to 0.
- R6: The stack holds STACK_DEPTH = 2 return addresses. A third push discards the oldest entry, so nested returns give the newest address, then the second newest, then the second newest again.
- R7: A skip squashes the next slot, which is the word at the executing address plus one. Execution then resumes at the executing address plus two, with wrap-around.
- R8: Requests raised during a squashed slot are ignored. They do not change the flow or the stack.
- R9: When several requests are raised in one slot, call wins over jump, jump over return, and return over skip.
- R10: A squashed slot always drives `instr` to 0x000 with `squash` = 1. It is always followed by an unsquashed slot. An unsquashed slot passes `pmData` through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| jumpReq | input | 1 | Jump request for the executing instruction |
| callReq | input | 1 | Subroutine call request |
| retReq | input | 1 | Subroutine return request |
| skipReq | input | 1 | Skip the next instruction |
| target | input | 11 | Destination taken from the literal field |
| pmData | input | 12 | Registered program memory read data |
| pmAddr | output | 11 | Program memory fetch address |
| instr | output | 12 | Instruction in the execute slot, zero when squashed |
| squash | output | 1 | High in a slot whose instruction is cancelled |

## Verification
The assertions check the following on every cycle:
- the address advances by one when no load is taken;
- a jump, call or return redirects the fetch address on the next cycle;
- a push moves the stack down and a return pops it;
- each squash lasts exactly one slot;
- requests are masked in a squashed slot.

Whole sequences can only be shown by the bench's scenarios:
- the address-zero start after reset;
- wrap at the top of the code space;
- three-deep call nesting with the lost entry;
- skips across the wrap;
- the full priority sweep of request combinations;
- the words that actually reach the execute slot.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;

  // Strobes from the flow control to the address datapath
  typedef struct packed {
    logic loadTarget;  // next fetch comes from the literal target
    logic loadReturn;  // next fetch comes from the stack top
    logic push;        // push the return address
    logic pop;         // pop the stack
    logic squash;      // current slot is cancelled
  } seqStrobe_t;

endpackage

// File: rtl/fetch_seq_ctl.sv
module fetch_seq_ctl
  import fetch_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       jumpReq,
  input  logic       callReq,
  input  logic       retReq,
  input  logic       skipReq,
  output seqStrobe_t strb
);

  logic squashQ;
  logic live;
  logic taken;

  // Requests only count in a slot holding a real instruction
  assign live  = !squashQ;
  assign taken = live && (jumpReq || callReq || retReq || skipReq);

  always_comb begin
    strb            = '0;
    strb.squash     = squashQ;
    strb.push       = live && callReq;
    strb.loadTarget = live && (callReq || jumpReq);
    strb.loadReturn = live && retReq && !callReq && !jumpReq;
    strb.pop        = strb.loadReturn;
  end

  // Reset cancels the first slot, and so does every taken request
  always_ff @(posedge clk) begin
    if (rst) squashQ <= 1'b1;
    else     squashQ <= taken;
  end

  p_one_bubble_r10: assert property (@(posedge clk) disable iff (rst)
    squashQ |=> !squashQ);

  p_taken_squash_r7: assert property (@(posedge clk) disable iff (rst)
    (!squashQ && (jumpReq || callReq || retReq || skipReq)) |=> squashQ);

  p_masked_r8: assert property (@(posedge clk) disable iff (rst)
    squashQ |-> !(strb.push || strb.loadTarget || strb.loadReturn));

  p_priority_r9: assert property (@(posedge clk) disable iff (rst)
    (strb.loadReturn || strb.push) |-> !(strb.loadReturn && strb.push));

endmodule

// File: rtl/fetch_seq_dp.sv
module fetch_seq_dp
  import fetch_seq_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int INSTR_W     = 12,
  parameter int STACK_DEPTH = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  seqStrobe_t         strb,
  input  logic [ADDR_W-1:0]  target,
  input  logic [INSTR_W-1:0] pmData,
  output logic [ADDR_W-1:0]  pmAddr,
  output logic [INSTR_W-1:0] instr
);

  localparam logic [ADDR_W-1:0]  LAST_ADDR = '1;
  localparam logic [ADDR_W-1:0]  ONE       = ADDR_W'(1);
  localparam logic [INSTR_W-1:0] NOP_WORD  = '0;

  // pc is the address of the slot now executing, or of the squashed slot
  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] pcInc;
  logic [STACK_DEPTH-1:0][ADDR_W-1:0] stk;

  assign pcInc  = pc + ONE;
  assign pmAddr = pcInc;

  // A load parks pc one below the destination, so the next sequential fetch
  // lands on it
  always_ff @(posedge clk) begin
    if (rst)                  pc <= LAST_ADDR;
    else if (strb.loadTarget) pc <= target - ONE;
    else if (strb.loadReturn) pc <= stk[0] - ONE;
    else                      pc <= pcInc;
  end

  generate
    if (STACK_DEPTH >= 2) begin : g_deep
      always_ff @(posedge clk) begin
        if (rst) begin
          stk <= '0;
        end else if (strb.push) begin
          for (int i = STACK_DEPTH - 1; i > 0; i--) stk[i] <= stk[i-1];
          stk[0] <= pcInc;
        end else if (strb.pop) begin
          for (int i = 0; i < STACK_DEPTH - 1; i++) stk[i] <= stk[i+1];
        end
      end

      p_drop_oldest_r6: assert property (@(posedge clk) disable iff (rst)
        strb.push |=> stk[STACK_DEPTH-1] == $past(stk[STACK_DEPTH-2]));

      p_pop_shift_r5: assert property (@(posedge clk) disable iff (rst)
        strb.pop |=> stk[0] == $past(stk[1]));
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst)            stk <= '0;
        else if (strb.push) stk[0] <= pcInc;
      end
    end
  endgenerate

  assign instr = strb.squash ? NOP_WORD : pmData;

  p_sequential_r2: assert property (@(posedge clk) disable iff (rst)
    (!strb.loadTarget && !strb.loadReturn) |=> pmAddr == $past(pmAddr) + ONE);

  p_jump_target_r3: assert property (@(posedge clk) disable iff (rst)
    strb.loadTarget |=> pmAddr == $past(target));

  p_push_link_r4: assert property (@(posedge clk) disable iff (rst)
    strb.push |=> stk[0] == $past(pmAddr));

  p_return_addr_r5: assert property (@(posedge clk) disable iff (rst)
    strb.loadReturn |=> pmAddr == $past(stk[0]));

endmodule

// File: rtl/fetch_sequencer.sv
module fetch_sequencer
  import fetch_seq_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int INSTR_W     = 12,
  parameter int STACK_DEPTH = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               jumpReq,
  input  logic               callReq,
  input  logic               retReq,
  input  logic               skipReq,
  input  logic [ADDR_W-1:0]  target,
  input  logic [INSTR_W-1:0] pmData,
  output logic [ADDR_W-1:0]  pmAddr,
  output logic [INSTR_W-1:0] instr,
  output logic               squash
);

  seqStrobe_t strb;

  fetch_seq_ctl i_ctl (
    .clk     (clk),
    .rst     (rst),
    .jumpReq (jumpReq),
    .callReq (callReq),
    .retReq  (retReq),
    .skipReq (skipReq),
    .strb    (strb)
  );

  fetch_seq_dp #(
    .ADDR_W      (ADDR_W),
    .INSTR_W     (INSTR_W),
    .STACK_DEPTH (STACK_DEPTH)
  ) i_dp (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .target (target),
    .pmData (pmData),
    .pmAddr (pmAddr),
    .instr  (instr)
  );

  assign squash = strb.squash;

endmodule

// File: tb/test_fetch_sequencer.sv
`timescale 1ns/1ps
module test_fetch_sequencer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        jumpReq = 1'b0, callReq = 1'b0, retReq = 1'b0, skipReq = 1'b0;
  logic [10:0] target = '0;
  logic [11:0] pmData = '0;
  logic [10:0] pmAddr;
  logic [11:0] instr;
  logic        squash;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  // Bench-side model state
  logic [10:0] mCur = '0, mResume = '0, mStk0 = '0, mStk1 = '0;
  bit          mSq = 1;

  always #5 clk = ~clk;

  // Program memory with a registered read; each word is tagged with its own address
  always_ff @(posedge clk) pmData <= {1'b1, pmAddr};

  fetch_sequencer i_fetch_sequencer (
    .clk(clk), .rst(rst), .jumpReq(jumpReq), .callReq(callReq),
    .retReq(retReq), .skipReq(skipReq), .target(target),
    .pmData(pmData), .pmAddr(pmAddr), .instr(instr), .squash(squash)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Called at a falling edge: check the slot, drive its requests, advance the model
  task automatic slot(input bit j, input bit c, input bit r, input bit s,
                      input logic [10:0] tgt, input string tag);
    logic [10:0] nextA;
    logic [10:0] skipA;
    nextA = mCur + 11'd1;
    skipA = mCur + 11'd2;
    if (mSq) begin
      chk(tag, "instr", 32'(instr), 32'h0);
      chk(tag, "squash", 32'(squash), 32'h1);
      chk(tag, "pmAddr", 32'(pmAddr), 32'(mResume));
    end else begin
      chk(tag, "instr", 32'(instr), 32'({1'b1, mCur}));
      chk(tag, "squash", 32'(squash), 32'h0);
      chk(tag, "pmAddr", 32'(pmAddr), 32'(nextA));
    end
    jumpReq = j; callReq = c; retReq = r; skipReq = s; target = tgt;
    if (mSq) begin
      mCur = mResume; mSq = 0;
    end else if (c) begin
      mStk1 = mStk0; mStk0 = nextA; mResume = tgt; mSq = 1;
    end else if (j) begin
      mResume = tgt; mSq = 1;
    end else if (r) begin
      mResume = mStk0; mStk0 = mStk1; mSq = 1;
    end else if (s) begin
      mResume = skipA; mSq = 1;
    end else begin
      mCur = nextA;
    end
    @(negedge clk);
  endtask

  task automatic run(input int n, input string tag);
    for (int k = 0; k < n; k++) slot(0, 0, 0, 0, 11'h0, tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1; jumpReq = 0; callReq = 0; retReq = 0; skipReq = 0;
    @(posedge clk);
    @(negedge clk);
    rst = 0;
    mSq = 1; mResume = '0; mStk0 = '0; mStk1 = '0; mCur = '0;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    doReset();
    // R1: reset slot squashed with fetch at 0, then word 0 executes
    run(3, "R1");
    // R2: plain sequential run
    run(20, "R2");
    // R2: wrap at the top of the code space
    slot(1, 0, 0, 0, 11'h7FD, "R3");
    run(6, "R2");
    // R3: jump sweep across the code space
    for (int t = 0; t < 2048; t += 37) begin
      slot(1, 0, 0, 0, 11'(t), "R3");
      run(2, "R3");
    end
    slot(1, 0, 0, 0, 11'h7FF, "R3");
    run(2, "R3");
    // R5: return with a freshly reset stack goes to 0
    doReset();
    run(2, "R5");
    slot(0, 0, 1, 0, 11'h0, "R5");
    run(2, "R5");
    // R4 and R5: call and return
    slot(1, 0, 0, 0, 11'h100, "R4");
    run(2, "R4");
    slot(0, 1, 0, 0, 11'h300, "R4");
    run(3, "R4");
    slot(0, 0, 1, 0, 11'h0, "R5");
    run(3, "R5");
    // R6: three nested calls, then three returns
    slot(0, 1, 0, 0, 11'h400, "R6");
    run(1, "R6");
    slot(0, 1, 0, 0, 11'h500, "R6");
    run(1, "R6");
    slot(0, 1, 0, 0, 11'h600, "R6");
    run(2, "R6");
    for (int k = 0; k < 3; k++) begin
      slot(0, 0, 1, 0, 11'h0, "R6");
      run(2, "R6");
    end
    // R7: skip in the middle of the space and across the wrap
    slot(0, 0, 0, 1, 11'h0, "R7");
    run(3, "R7");
    slot(1, 0, 0, 0, 11'h7FE, "R7");
    run(1, "R7");
    slot(0, 0, 0, 1, 11'h0, "R7");
    run(3, "R7");
    // R8: every request raised in a squashed slot is ignored
    slot(0, 1, 0, 0, 11'h222, "R8");
    slot(1, 1, 1, 1, 11'h555, "R8");
    run(2, "R8");
    slot(0, 0, 1, 0, 11'h0, "R8");
    run(2, "R8");
    // R9: all request combinations
    for (int m = 1; m < 16; m++) begin
      slot(m[0], m[1], m[2], m[3], 11'(m * 97), "R9");
      run(2, "R9");
    end
    // R10: back-to-back requests keep a single bubble per taken request
    for (int k = 0; k < 6; k++) slot(1, 0, 0, 0, 11'(k * 300), "R10");
    run(2, "R10");
    // R1: reset in the middle of a run
    slot(1, 0, 0, 0, 11'h345, "R1");
    doReset();
    run(3, "R1");
    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #(100_000 * 10);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

endmodule